// File: doc/BRIEF.md
# SD Host Vendor Register Bank

This block is the register front-end of an SD/eMMC host controller. It takes 32-bit word accesses inside a 4 KB window. Offsets below the slot base hit a local bank of host-specific registers. Offsets at or above the slot base are handed, rebased to zero, to an external block that holds the standard slot registers.

The local bank is plain read/write storage, with three exceptions:
- **General word at offset 0.** It holds a fixed identification value. Writing 1 to its bit 0 starts a soft reset that clears the whole bank and pulses a reset to the slot block.
- **PHY access word.** Its acknowledge bit answers at once whenever a PHY read or write is requested.
- **Timing control word.** Its tuning request bit never stores a 1.

The interrupt of the slot block passes straight through.

Top module: `sdhc_hostregs`

## Requirements
- R1: After reset, offset 0x000 reads 0x00010000 and every other local offset (0x004 to 0x1FC) reads 0.
- R2: Writes to offset 0x000 never change its contents, and its bit 0 always reads 0.
- R3: A full-word write to offset 0x000 with bit 0 set raises slot_srst in the cycle after the write, for exactly one cycle. On the edge that ends that cycle, every local register returns to its reset value.
- R4: On a write to offset 0x010, bit 26 is stored as 1 when bit 24 (PHY write request) or bit 25 (PHY read request) is set in the written data. Otherwise bit 26 is stored as 0. All other bits are stored as written.
- R5: On a write to offset 0x018, bit 15 is stored as 0 and all other bits are stored as written.
- R6: The other local offsets store full-word writes unchanged. Every local access returns rsp_valid exactly one cycle after the request, with the stored word on rsp_rdata for reads.
- R7: Requests at offset 0x200 and above are forwarded on the slot port in the same cycle, with slot_addr equal to the offset minus 0x200. Local offsets never assert slot_req_valid. Slot responses appear on the bus response.
- R8: A request whose byte enables are not all ones is not forwarded and changes no register. It gets a response one cycle later with rsp_err = 1 and rsp_rdata = 0.
- R9: irq always equals slot_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Error response |
| slot_req_valid | output | 1 | Forwarded request strobe |
| slot_req_write | output | 1 | Forwarded direction |
| slot_addr | output | 12 | Offset rebased to the slot base |
| slot_wdata | output | 32 | Forwarded write data |
| slot_rsp_valid | input | 1 | Slot response strobe |
| slot_rsp_rdata | input | 32 | Slot read data |
| slot_rsp_err | input | 1 | Slot error response |
| slot_irq | input | 1 | Slot interrupt |
| irq | output | 1 | Interrupt output |
| slot_srst | output | 1 | One-cycle soft reset to the slot block |

## Verification
The hardest case to reach from the ports is a soft reset that wipes registers which hold non-reset values. That requires registers that were loaded beforehand, and a slot_srst pulse that is checked in the exact cycle after the write and again one cycle later.

The bench first fills a plain word, the PHY word and the timing word through the vector table. It then issues the reset write, samples slot_srst on two consecutive cycles, and reads the loaded words back to confirm they are cleared.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
   localparam int PHY_WR_BIT  = 24;
   localparam int PHY_RD_BIT  = 25;
   localparam int PHY_ACK_BIT = 26;
   localparam int TUNE_BIT    = 15;
   localparam int SRST_BIT    = 0;

   typedef enum logic [1:0] {
      WK_FIXED = 2'd0,
      WK_PHY   = 2'd1,
      WK_TUNE  = 2'd2,
      WK_PLAIN = 2'd3
   } word_kind_e;

   function automatic logic [31:0] shape_phy(input logic [31:0] w);
      logic [31:0] r;
      r = w;
      r[PHY_ACK_BIT] = w[PHY_WR_BIT] | w[PHY_RD_BIT];
      return r;
   endfunction

   function automatic logic [31:0] shape_tune(input logic [31:0] w);
      logic [31:0] r;
      r = w;
      r[TUNE_BIT] = 1'b0;
      return r;
   endfunction
endpackage

// File: rtl/hostreg_decode.sv
module hostreg_decode #(
   parameter int ADDR_W    = 12,
   parameter int BE_W      = 4,
   parameter int SLOT_BASE = 'h200,
   parameter int IDX_W     = 7
) (
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BE_W-1:0]   req_be,
   output logic              be_ok,
   output logic              hit_local,
   output logic              hit_slot,
   output logic              hit_bad,
   output logic [IDX_W-1:0]  word_idx,
   output logic [ADDR_W-1:0] slot_off
);
   logic above;

   assign be_ok     = &req_be;
   assign above     = req_addr >= ADDR_W'(SLOT_BASE);
   assign hit_local = req_valid & be_ok & ~above;
   assign hit_slot  = req_valid & be_ok & above;
   assign hit_bad   = req_valid & ~be_ok;
   assign word_idx  = req_addr[IDX_W+1:2];
   assign slot_off  = req_addr - ADDR_W'(SLOT_BASE);
endmodule

// File: rtl/hostreg_store.sv
module hostreg_store
   import hostreg_pkg::*;
#(
   parameter int          DATA_W   = 32,
   parameter int          WORDS    = 128,
   parameter int          IDX_W    = 7,
   parameter int          PHY_IDX  = 4,
   parameter int          TUNE_IDX = 6,
   parameter logic [31:0] GEN_VAL  = 32'h0001_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] words [WORDS];

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      localparam word_kind_e KIND = (i == 0)        ? WK_FIXED :
                                    (i == PHY_IDX)  ? WK_PHY   :
                                    (i == TUNE_IDX) ? WK_TUNE  : WK_PLAIN;
      if (KIND == WK_FIXED) begin : g_fixed
         assign words[i] = DATA_W'(GEN_VAL);
      end else begin : g_reg
         logic [DATA_W-1:0] q;
         logic [DATA_W-1:0] nxt;
         logic              hit;
         assign hit = wr_en && (wr_idx == IDX_W'(i));
         if (KIND == WK_PHY) begin : g_phy
            assign nxt = shape_phy(wr_data);
         end else if (KIND == WK_TUNE) begin : g_tune
            assign nxt = shape_tune(wr_data);
         end else begin : g_plain
            assign nxt = wr_data;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (clr) q <= '0;
            else if (hit) q <= nxt;
         end
         assign words[i] = q;
      end
   end

   assign rd_data = words[rd_idx];
endmodule

// File: rtl/hostreg_resp.sv
module hostreg_resp #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loc_req,
   input  logic              bad_req,
   input  logic              loc_read,
   input  logic [DATA_W-1:0] loc_data,
   input  logic              slot_rsp_valid,
   input  logic [DATA_W-1:0] slot_rsp_rdata,
   input  logic              slot_rsp_err,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err
);
   logic              vld_q;
   logic              err_q;
   logic [DATA_W-1:0] dat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         err_q <= 1'b0;
         dat_q <= '0;
      end else begin
         vld_q <= loc_req | bad_req;
         err_q <= bad_req;
         dat_q <= (loc_req && loc_read) ? loc_data : '0;
      end
   end

   assign rsp_valid = vld_q | slot_rsp_valid;
   assign rsp_rdata = vld_q ? dat_q : slot_rsp_rdata;
   assign rsp_err   = vld_q ? err_q : slot_rsp_err;
endmodule

// File: rtl/sdhc_hostregs.sv
module sdhc_hostregs
   import hostreg_pkg::*;
#(
   parameter int          ADDR_W    = 12,
   parameter int          DATA_W    = 32,
   parameter int          SLOT_BASE = 'h200,
   parameter int          PHY_OFF   = 'h10,
   parameter int          TUNE_OFF  = 'h18,
   parameter logic [31:0] GEN_VAL   = 32'h0001_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W/8-1:0] req_be,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              slot_req_valid,
   output logic              slot_req_write,
   output logic [ADDR_W-1:0] slot_addr,
   output logic [DATA_W-1:0] slot_wdata,
   input  logic              slot_rsp_valid,
   input  logic [DATA_W-1:0] slot_rsp_rdata,
   input  logic              slot_rsp_err,
   input  logic              slot_irq,
   output logic              irq,
   output logic              slot_srst
);
   localparam int BE_W   = DATA_W / 8;
   localparam int WORDS  = SLOT_BASE / 4;
   localparam int IDX_W  = $clog2(WORDS);

   if (DATA_W != 32) begin : g_chk_dw
      $error("DATA_W must be 32");
   end
   if ((SLOT_BASE % 4) != 0 || SLOT_BASE < 32 || SLOT_BASE >= (1 << ADDR_W)) begin : g_chk_base
      $error("SLOT_BASE must be word aligned and inside the window");
   end
   if ((1 << IDX_W) != WORDS) begin : g_chk_pow2
      $error("SLOT_BASE/4 must be a power of two");
   end

   logic             be_ok, hit_local, hit_slot, hit_bad;
   logic [IDX_W-1:0] word_idx;
   logic [DATA_W-1:0] rd_word;
   logic             loc_wr, srst_req, srst_q;

   hostreg_decode #(
      .ADDR_W(ADDR_W), .BE_W(BE_W), .SLOT_BASE(SLOT_BASE), .IDX_W(IDX_W)
   ) u_dec (
      .req_valid(req_valid), .req_addr(req_addr), .req_be(req_be),
      .be_ok(be_ok), .hit_local(hit_local), .hit_slot(hit_slot),
      .hit_bad(hit_bad), .word_idx(word_idx), .slot_off(slot_addr)
   );

   assign loc_wr   = hit_local & req_write;
   assign srst_req = loc_wr && (word_idx == '0) && req_wdata[SRST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) srst_q <= 1'b0;
      else        srst_q <= srst_req;
   end

   hostreg_store #(
      .DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W),
      .PHY_IDX(PHY_OFF / 4), .TUNE_IDX(TUNE_OFF / 4), .GEN_VAL(GEN_VAL)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .clr(srst_q),
      .wr_en(loc_wr), .wr_idx(word_idx), .wr_data(req_wdata),
      .rd_idx(word_idx), .rd_data(rd_word)
   );

   hostreg_resp #(.DATA_W(DATA_W)) u_resp (
      .clk(clk), .rst_n(rst_n),
      .loc_req(hit_local), .bad_req(hit_bad), .loc_read(~req_write),
      .loc_data(rd_word),
      .slot_rsp_valid(slot_rsp_valid), .slot_rsp_rdata(slot_rsp_rdata),
      .slot_rsp_err(slot_rsp_err),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
   );

   assign slot_req_valid = hit_slot;
   assign slot_req_write = req_write;
   assign slot_wdata     = req_wdata;
   assign irq            = slot_irq;
   assign slot_srst      = srst_q;
endmodule

// File: rtl/hostregs_chk.sv
module hostregs_chk #(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int SLOT_BASE = 'h200
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_wdata,
   input logic [DATA_W/8-1:0] req_be,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              slot_req_valid,
   input logic              slot_srst
);
   logic full_be;
   assign full_be = &req_be;

   AST_SRST_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && full_be && req_addr == '0 && req_wdata[0]) |=> slot_srst); // R3
   AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      slot_srst |=> !slot_srst); // R3
   AST_BAD_BE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !full_be) |=> (rsp_valid && rsp_err && rsp_rdata == '0)); // R8
   AST_BAD_BE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !full_be) |-> !slot_req_valid); // R8
   AST_LOCAL_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr < ADDR_W'(SLOT_BASE)) |-> !slot_req_valid); // R7
   AST_LOCAL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && full_be && req_addr < ADDR_W'(SLOT_BASE)) |=> (rsp_valid && !rsp_err)); // R6
endmodule

bind sdhc_hostregs hostregs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_BASE(SLOT_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
   .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
   .slot_req_valid(slot_req_valid), .slot_srst(slot_srst)
);

// File: tb/sdhc_hostregs_bench.sv
module sdhc_hostregs_bench;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_be = 4'hF;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic        slot_req_valid, slot_req_write;
   logic [11:0] slot_addr;
   logic [31:0] slot_wdata;
   logic        slot_rsp_valid = 1'b0, slot_rsp_err = 1'b0;
   logic [31:0] slot_rsp_rdata = '0;
   logic        slot_irq = 1'b0;
   logic        irq, slot_srst;

   int errors = 0;
   int checks = 0;
   logic        got_valid, got_err, got_fwd;
   logic [31:0] got_data;
   logic [11:0] got_saddr;

   always #(PERIOD/2) clk = ~clk;

   sdhc_hostregs u_sdhc_hostregs (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .slot_req_valid(slot_req_valid), .slot_req_write(slot_req_write),
      .slot_addr(slot_addr), .slot_wdata(slot_wdata),
      .slot_rsp_valid(slot_rsp_valid), .slot_rsp_rdata(slot_rsp_rdata),
      .slot_rsp_err(slot_rsp_err), .slot_irq(slot_irq), .irq(irq),
      .slot_srst(slot_srst)
   );

   // Model of the slot block: answers one cycle later with a tagged word.
   always_ff @(posedge clk) begin
      slot_rsp_valid <= slot_req_valid;
      slot_rsp_rdata <= 32'hC0DE_0000 | {20'h0, slot_addr};
      slot_rsp_err   <= 1'b0;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One request, driven at a falling edge; response sampled at the next falling edge.
   task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                         input logic [3:0] be);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      #1;
      got_fwd   = slot_req_valid;
      got_saddr = slot_addr;
      @(negedge clk);
      req_valid = 1'b0;
      got_valid = rsp_valid;
      got_err   = rsp_err;
      got_data  = rsp_rdata;
   endtask

   typedef struct packed {
      logic [11:0] addr;
      logic [31:0] wdata;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{12'h004, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 8'd6},  // R6
      '{12'h1FC, 32'h1234_5678, 32'h1234_5678, 8'd6},  // R6
      '{12'h010, 32'h0100_0000, 32'h0500_0000, 8'd4},  // R4 write request
      '{12'h010, 32'h0200_0055, 32'h0600_0055, 8'd4},  // R4 read request
      '{12'h010, 32'h0400_0000, 32'h0000_0000, 8'd4},  // R4 ack alone is dropped
      '{12'h010, 32'h0300_0001, 32'h0700_0001, 8'd4},  // R4 both requests
      '{12'h018, 32'hFFFF_FFFF, 32'hFFFF_7FFF, 8'd5},  // R5
      '{12'h018, 32'h0000_8001, 32'h0000_0001, 8'd5},  // R5
      '{12'h000, 32'hFFFF_FFFE, 32'h0001_0000, 8'd2},  // R2
      '{12'h008, 32'h0000_00AA, 32'h0000_00AA, 8'd6}   // R6
   };

   task automatic finish_report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(PERIOD * 200000);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      access(1'b0, 12'h000, '0, 4'hF); check("R1 offset 0", got_data, 32'h0001_0000);
      access(1'b0, 12'h010, '0, 4'hF); check("R1 offset 0x10", got_data, 32'h0);
      access(1'b0, 12'h100, '0, 4'hF); check("R1 offset 0x100", got_data, 32'h0);
      check("R1 srst idle", {31'h0, slot_srst}, 32'h0);

      // Vector table: write, then read back
      for (int i = 0; i < 10; i++) begin
         access(1'b1, VECS[i].addr, VECS[i].wdata, 4'hF);
         access(1'b0, VECS[i].addr, '0, 4'hF);
         check($sformatf("R%0d vector %0d readback", VECS[i].req, i), got_data, VECS[i].exp);
         check($sformatf("R%0d vector %0d latency", VECS[i].req, i), {31'h0, got_valid}, 32'h1);
      end

      // R8 partial byte enables
      access(1'b1, 12'h008, 32'h5555_5555, 4'h3);
      check("R8 write err", {31'h0, got_err}, 32'h1);
      access(1'b0, 12'h008, '0, 4'hF);
      check("R8 write ignored", got_data, 32'h0000_00AA);
      access(1'b0, 12'h008, '0, 4'h1);
      check("R8 read zero", got_data, 32'h0);
      check("R8 read err", {31'h0, got_err}, 32'h1);
      access(1'b0, 12'h204, '0, 4'h7);
      check("R8 not forwarded", {31'h0, got_fwd}, 32'h0);

      // R7 forwarding
      access(1'b0, 12'h204, '0, 4'hF);
      check("R7 forwarded", {31'h0, got_fwd}, 32'h1);
      check("R7 rebased addr", {20'h0, got_saddr}, 32'h4);
      check("R7 slot data", got_data, 32'hC0DE_0004);
      access(1'b0, 12'h1FC, '0, 4'hF);
      check("R7 local not forwarded", {31'h0, got_fwd}, 32'h0);

      // R9 interrupt pass-through
      slot_irq = 1'b1; #1; check("R9 irq high", {31'h0, irq}, 32'h1);
      slot_irq = 1'b0; #1; check("R9 irq low", {31'h0, irq}, 32'h0);

      // R3 soft reset wipes loaded registers
      access(1'b1, 12'h000, 32'h0000_0001, 4'hF);
      check("R3 srst pulse", {31'h0, slot_srst}, 32'h1);
      @(negedge clk);
      check("R3 srst one cycle", {31'h0, slot_srst}, 32'h0);
      access(1'b0, 12'h008, '0, 4'hF); check("R3 plain cleared", got_data, 32'h0);
      access(1'b0, 12'h010, '0, 4'hF); check("R3 phy cleared", got_data, 32'h0);
      access(1'b0, 12'h018, '0, 4'hF); check("R3 tune cleared", got_data, 32'h0);
      access(1'b0, 12'h1FC, '0, 4'hF); check("R3 top word cleared", got_data, 32'h0);
      access(1'b0, 12'h000, '0, 4'hF); check("R3 general kept", got_data, 32'h0001_0000);

      finish_report();
   end
endmodule